// File: doc/BRIEF.md
# Indexed Colour Palette Interface

This block holds a 256-entry colour lookup table and the register front end that software uses to fill it. The bus is 32 bits wide, but every address and data byte travels in bits 31:24 of the word. A port-select code picks one of three ports: the index register, the colour port and the control port. Software loads the index register with an entry number. It then writes the red, green and blue bytes of that entry to the colour port, one after another. Reading the colour port returns the bytes in the same order. The index register steps to the next entry after each complete triple, so a whole table can be streamed with a single index write.

The control port uses the same index register to reach four byte-wide control registers at indices 4 to 7. The register at index 4 is the read mask. The register at index 6 is an overlay control byte. The registers at indices 5 and 7 are general-purpose. On the pixel side, an 8-bit colour index is masked by the read mask and looked up in the table. The 24-bit colour appears on the output one clock later.

Top module: `clut_palette_if`

## Requirements
- R1: After reset, the index register is 0 and the sequence is at red. `bus_rdata` and `pix_rgb` are 0. The control registers hold 0xFF (index 4), 0x00 (index 5), 0x73 (index 6) and 0x00 (index 7).
- R2: Only bits 31:24 of a write word are used. Every read word carries its byte in bits 31:24, with bits 23:0 at zero.
- R3: A write with port code 0 loads the index register from the data byte and returns the sequence to red. A colour write that was in progress is dropped.
- R4: Colour writes (port code 1) store red, then green, then blue. The entry changes only on the blue write, to the full triple; a pixel lookup before that write still returns the old colour.
- R5: After the blue step of a colour write or read, the index register increments, wrapping from 255 to 0, and the sequence returns to red.
- R6: A read with port code 1 returns red, green and blue of the addressed entry in that order, using the same sequence counter as writes. Read data appears on `bus_rdata` in the clock after the strobe and is 0 in any cycle that follows no read.
- R7: The control port (port code 2) writes and reads the register whose index matches the index register (4 to 7). At any other index, control writes change nothing and reads return 0. Control accesses leave the index register and the sequence unchanged. Port code 3 is ignored on writes and reads 0.
- R8: `pix_rgb` equals the entry at (`pix_index` AND read mask), packed red in 23:16, green in 15:8, blue in 7:0, one clock after `pix_index` is presented.
- R9: A pixel lookup made in the same clock as the blue write to that entry returns the entry's previous colour. The next lookup returns the new colour.
- R10: A read with port code 0 returns the index register value.
- R11: When the bus write and read strobes are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_sel | input | 2 | Port code: 0 index, 1 colour, 2 control, 3 unused |
| bus_wdata | input | 32 | Write word; byte in bits 31:24 |
| bus_rdata | output | 32 | Registered read word; byte in bits 31:24 |
| pix_index | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Registered pixel colour {red, green, blue} |

## Verification
A bus write takes effect at the clock edge where its strobe is sampled. Read data is registered and is due one clock after the read strobe. A pixel colour is due one clock after its index is presented. The bench drives all stimulus on falling edges and samples each result at the next falling edge, exactly one rising edge later. For the same-cycle commit case, the pixel output is sampled at two consecutive falling edges: the first must show the old colour and the second the new one.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int BUS_W   = 32;
    localparam int LANE_W  = 8;
    localparam int LANE_LO = BUS_W - LANE_W;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_COLOUR = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic [LANE_W-1:0] r;
        logic [LANE_W-1:0] g;
        logic [LANE_W-1:0] b;
    } rgb_t;

    function automatic logic [LANE_W-1:0] lane_of(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:LANE_LO];
    endfunction

    function automatic logic [BUS_W-1:0] to_lane(input logic [LANE_W-1:0] b);
        return {b, {LANE_LO{1'b0}}};
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] ctrl_reset_val(input int slot);
        case (slot)
            0:       return 8'hFF;
            2:       return 8'h73;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              col_wr,
    input  logic              col_rd,
    input  logic [LANE_W-1:0] wbyte,
    output logic [AW-1:0]     addr,
    output phase_e            phase,
    output logic              commit,
    output logic [LANE_W-1:0] stage_r,
    output logic [LANE_W-1:0] stage_g
);

    logic step;

    assign step   = col_wr || col_rd;
    assign commit = col_wr && (phase == PH_BLU);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            phase   <= PH_RED;
            stage_r <= '0;
            stage_g <= '0;
        end else if (idx_wr) begin
            addr  <= AW'(wbyte);
            phase <= PH_RED;
        end else if (step) begin
            if (col_wr && phase == PH_RED) stage_r <= wbyte;
            if (col_wr && phase == PH_GRN) stage_g <= wbyte;
            if (phase == PH_BLU) addr <= addr + AW'(1);
            phase <= next_phase(phase);
        end
    end

    // R3
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (addr == $past(AW'(wbyte)) && phase == PH_RED));

    // R5
    blue_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !idx_wr && phase == PH_BLU) |=>
            (addr == $past(addr) + AW'(1) && phase == PH_RED));

    // R4
    no_early_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (col_wr && !idx_wr && phase == PH_RED) |=> !commit || phase != PH_BLU);

endmodule

// File: rtl/clut_ctrl_regs.sv
module clut_ctrl_regs
    import clut_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BASE = 4,
    parameter int NREG = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ctrl_wr,
    input  logic [AW-1:0]                 addr,
    input  logic [LANE_W-1:0]             wbyte,
    output logic [NREG-1:0][LANE_W-1:0]   regs,
    output logic [LANE_W-1:0]             rd_byte
);

    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic          hit;
    logic [AW-1:0] rel;

    assign rel = addr - AW'(BASE);
    assign hit = (addr >= AW'(BASE)) && (addr < AW'(BASE + NREG));

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= ctrl_reset_val(i);
                else if (ctrl_wr && addr == AW'(BASE + i))
                    regs[i] <= wbyte;
            end
        end
    endgenerate

    always_comb begin
        rd_byte = '0;
        if (hit) rd_byte = regs[rel[IW-1:0]];
    end

    // R7
    ctrl_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !hit) |=> $stable(regs));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_addr,
    input  rgb_t              wr_data,
    input  logic [IW-1:0]     rd_addr,
    input  phase_e            rd_phase,
    output logic [LANE_W-1:0] rd_byte,
    input  logic [IW-1:0]     pix_addr,
    output rgb_t              pix_out
);

    rgb_t mem [ENTRIES];
    rgb_t rd_ent;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= mem[pix_addr];
    end

    assign rd_ent = mem[rd_addr];

    always_comb begin
        case (rd_phase)
            PH_RED:  rd_byte = rd_ent.r;
            PH_GRN:  rd_byte = rd_ent.g;
            default: rd_byte = rd_ent.b;
        endcase
    end

endmodule

// File: rtl/clut_palette_if.sv
module clut_palette_if
    import clut_pkg::*;
#(
    parameter int ENTRIES   = 256,
    parameter int CTRL_BASE = 4,
    parameter int CTRL_NREG = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  pix_index,
    output logic [23:0] pix_rgb
);

    localparam int IW = $clog2(ENTRIES);

    port_sel_e                          sel;
    logic                               rd_go;
    logic                               idx_wr, col_wr, col_rd, ctrl_wr;
    logic [LANE_W-1:0]                  wbyte;
    logic [IW-1:0]                      addr;
    phase_e                             phase;
    logic                               commit;
    logic [LANE_W-1:0]                  stage_r, stage_g;
    logic [CTRL_NREG-1:0][LANE_W-1:0]   ctrl_q;
    logic [LANE_W-1:0]                  ctrl_rd, col_byte;
    logic [IW-1:0]                      pix_addr;
    rgb_t                               entry_in, pix_q;

    assign sel     = port_sel_e'(bus_sel);
    assign wbyte   = lane_of(bus_wdata);
    assign rd_go   = bus_rd && !bus_wr;
    assign idx_wr  = bus_wr && sel == SEL_INDEX;
    assign col_wr  = bus_wr && sel == SEL_COLOUR;
    assign ctrl_wr = bus_wr && sel == SEL_CTRL;
    assign col_rd  = rd_go  && sel == SEL_COLOUR;

    clut_seq #(.AW(IW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .idx_wr  (idx_wr),
        .col_wr  (col_wr),
        .col_rd  (col_rd),
        .wbyte   (wbyte),
        .addr    (addr),
        .phase   (phase),
        .commit  (commit),
        .stage_r (stage_r),
        .stage_g (stage_g)
    );

    clut_ctrl_regs #(.AW(IW), .BASE(CTRL_BASE), .NREG(CTRL_NREG)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .addr    (addr),
        .wbyte   (wbyte),
        .regs    (ctrl_q),
        .rd_byte (ctrl_rd)
    );

    assign entry_in = '{r: stage_r, g: stage_g, b: wbyte};
    assign pix_addr = IW'(pix_index & ctrl_q[0]);

    clut_store #(.ENTRIES(ENTRIES), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (commit),
        .wr_addr  (addr),
        .wr_data  (entry_in),
        .rd_addr  (addr),
        .rd_phase (phase),
        .rd_byte  (col_byte),
        .pix_addr (pix_addr),
        .pix_out  (pix_q)
    );

    assign pix_rgb = pix_q;

    always_ff @(posedge clk) begin
        if (rst || !rd_go) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                SEL_INDEX:  bus_rdata <= to_lane(LANE_W'(addr));
                SEL_COLOUR: bus_rdata <= to_lane(col_byte);
                SEL_CTRL:   bus_rdata <= to_lane(ctrl_rd);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R6
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> bus_rdata == 32'h0);

    // R7
    ctrl_keeps_seq_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ($stable(addr) && $stable(phase)));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rd) |=> bus_rdata == 32'h0);

endmodule

// File: tb/clut_palette_if_tb.sv
`timescale 1ns/1ps
module clut_palette_if_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_index = 8'h0;
    logic [23:0] pix_rgb;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clut_palette_if u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_index (pix_index),
        .pix_rgb   (pix_rgb)
    );

    // vector: {op[1:0], sel[1:0], data[7:0], exp[23:0]}; op 0 write, 1 read check, 2 pixel check
    localparam int NV = 30;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'h10, 24'h0},      {2'd0, 2'd1, 8'h11, 24'h0},
        {2'd0, 2'd1, 8'h22, 24'h0},      {2'd0, 2'd1, 8'h33, 24'h0},
        {2'd1, 2'd0, 8'h00, 24'h11},     {2'd0, 2'd0, 8'h10, 24'h0},
        {2'd1, 2'd1, 8'h00, 24'h11},     {2'd1, 2'd1, 8'h00, 24'h22},
        {2'd1, 2'd1, 8'h00, 24'h33},     {2'd1, 2'd0, 8'h00, 24'h11},
        {2'd2, 2'd0, 8'h10, 24'h112233}, {2'd0, 2'd0, 8'hFF, 24'h0},
        {2'd0, 2'd1, 8'hAA, 24'h0},      {2'd0, 2'd1, 8'hBB, 24'h0},
        {2'd0, 2'd1, 8'hCC, 24'h0},      {2'd1, 2'd0, 8'h00, 24'h00},
        {2'd2, 2'd0, 8'hFF, 24'hAABBCC}, {2'd0, 2'd0, 8'h0F, 24'h0},
        {2'd0, 2'd1, 8'h44, 24'h0},      {2'd0, 2'd1, 8'h55, 24'h0},
        {2'd0, 2'd1, 8'h66, 24'h0},      {2'd0, 2'd0, 8'h04, 24'h0},
        {2'd0, 2'd2, 8'h0F, 24'h0},      {2'd1, 2'd2, 8'h00, 24'h0F},
        {2'd2, 2'd0, 8'h1F, 24'h445566}, {2'd0, 2'd0, 8'h04, 24'h0},
        {2'd0, 2'd2, 8'hFF, 24'h0},      {2'd1, 2'd2, 8'h00, 24'hFF},
        {2'd2, 2'd0, 8'h10, 24'h112233}, {2'd1, 2'd0, 8'h00, 24'h04}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic bread(input logic [1:0] s, output logic [31:0] q);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = s;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    task automatic pix(input logic [7:0] i, output logic [23:0] q);
        @(negedge clk);
        pix_index = i;
        @(negedge clk);
        q = pix_rgb;
    endtask

    initial begin
        #(200000 * 20);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [23:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pix", {8'h0, pix_rgb}, 32'h0);
        bread(2'd0, q); check("R1 index", q, 32'h0);
        bwrite(2'd0, 32'h04000000); bread(2'd2, q); check("R1 ctrl4", q, 32'hFF000000);
        bwrite(2'd0, 32'h05000000); bread(2'd2, q); check("R1 ctrl5", q, 32'h00000000);
        bwrite(2'd0, 32'h06000000); bread(2'd2, q); check("R1 ctrl6", q, 32'h73000000);
        bwrite(2'd0, 32'h07000000); bread(2'd2, q); check("R1 ctrl7", q, 32'h00000000);

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic [1:0]  s;
            logic [7:0]  d;
            logic [23:0] e;
            {op, s, d, e} = VEC[k];
            if (op == 2'd0) begin
                bwrite(s, {d, 24'h0});
            end else if (op == 2'd1) begin
                bread(s, q);
                if (s == 2'd0)      check("R10 table", q, {e[7:0], 24'h0});
                else if (s == 2'd1) check("R6 table", q, {e[7:0], 24'h0});
                else                check("R7 table", q, {e[7:0], 24'h0});
            end else begin
                pix(d, p);
                check("R8 table", {8'h0, p}, {8'h0, e});
            end
        end

        // R2 low bits ignored, read lane
        bwrite(2'd0, 32'h12ABCDEF);
        bread(2'd0, q); check("R2", q, 32'h12000000);

        // R3 index write restarts the triple
        bwrite(2'd0, 32'h20000000);
        bwrite(2'd1, 32'h01000000);
        bwrite(2'd0, 32'h20000000);
        bwrite(2'd1, 32'h0A000000);
        bwrite(2'd1, 32'h0B000000);
        bwrite(2'd1, 32'h0C000000);
        pix(8'h20, p); check("R3", {8'h0, p}, 32'h000A0B0C);

        // R4 no commit before blue
        bwrite(2'd0, 32'h20000000);
        bwrite(2'd1, 32'h99000000);
        bwrite(2'd1, 32'h98000000);
        pix(8'h20, p); check("R4 before blue", {8'h0, p}, 32'h000A0B0C);
        bwrite(2'd1, 32'h97000000);
        pix(8'h20, p); check("R4 after blue", {8'h0, p}, 32'h00999897);

        // R9 same-cycle commit and lookup
        bwrite(2'd0, 32'h30000000);
        bwrite(2'd1, 32'h01000000);
        bwrite(2'd1, 32'h02000000);
        bwrite(2'd1, 32'h03000000);
        bwrite(2'd0, 32'h30000000);
        bwrite(2'd1, 32'h04000000);
        bwrite(2'd1, 32'h05000000);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 32'h06000000; pix_index = 8'h30;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
        check("R9 old", {8'h0, pix_rgb}, 32'h00010203);
        @(negedge clk);
        check("R9 new", {8'h0, pix_rgb}, 32'h00040506);

        // R5 wrap via reads
        bwrite(2'd0, 32'hFF000000);
        bread(2'd1, q); bread(2'd1, q); bread(2'd1, q);
        check("R6 blue of 0xFF", q, 32'hCC000000);
        bread(2'd0, q); check("R5 wrap", q, 32'h00000000);

        // R7 control write at an unmapped index, and port code 3
        bwrite(2'd0, 32'h09000000);
        bwrite(2'd2, 32'h5A000000);
        bread(2'd2, q); check("R7 unmapped read", q, 32'h0);
        bread(2'd0, q); check("R7 index kept", q, 32'h09000000);
        bwrite(2'd0, 32'h05000000);
        bread(2'd2, q); check("R7 ctrl5 untouched", q, 32'h0);
        bwrite(2'd3, 32'h77000000);
        bread(2'd0, q); check("R7 code3 write", q, 32'h05000000);
        bread(2'd3, q); check("R7 code3 read", q, 32'h0);

        // R11 write wins over read
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_sel = 2'd0; bus_wdata = 32'h42000000;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 32'h0;
        check("R11 no read data", bus_rdata, 32'h0);
        bread(2'd0, q); check("R11 write done", q, 32'h42000000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule